// File: doc/BRIEF.md
# Two-Choice Load-Aware Server Dispatcher

This block picks a backend server for each flow it is shown. For the first packet of a flow, two hashes of the flow key name two candidate servers. Each candidate's backlog is estimated from the most recent feedback that server sent: a reported queue length, a drain rate and the time of the report. The candidate with the smaller estimate wins. The chosen server index is then written into outgoing packet fields by logic outside this block.

Later packets of the same flow carry that index back to the block, which forwards it unchanged. This is how the block holds no per-flow memory. Feedback arrives on its own write port at any time. The current time comes from a free-running counter input. A result leaves a fixed four cycles after its key enters, and the block accepts a key every cycle.

Top module: `p2c_dispatch`

## Requirements
- R1: For a new flow, the two candidates are A = bits [31:28] of (key × 0x9E3779B1 mod 2^32) and B = bits [31:28] of (key × 0x85EBCA77 mod 2^32). The chosen server is always A or B.
- R2: A server's estimated load is max(0, q − d). Here q is its reported queue length and d = v × ((now − t) mod 2^16), with v the reported drain rate and t the report time.
- R3: When B's estimated load is strictly lower than A's, the output is B. Otherwise it is A.
- R4: Equal estimated loads choose A. When A and B are the same server, that server is chosen.
- R5: For a packet whose new-flow flag is 0, the output is the echoed server ID. Stored feedback has no effect on it.
- R6: A feedback write to a server replaces its queue length, drain rate and report time. Every lookup presented in a later cycle uses the new values.
- R7: A feedback write and a new-flow key presented in the same cycle give that key the values stored before the write.
- R8: out_valid is high exactly in cycle c+4 for each cycle c in which in_valid is high. Keys may arrive in back-to-back cycles.
- R9: After reset, out_valid is low and every server's stored state is zero, so a new flow chooses candidate A.
- R10: The product d saturates at 2^16 − 1 and does not wrap. A drain that exceeds the queue gives a load of zero.
- R11: The elapsed time now − t is taken modulo 2^16, so a time counter that has wrapped past the report time still ages the load correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A lookup is presented this cycle |
| in_new | input | 1 | 1: first packet of a flow; 0: use the echoed ID |
| in_key | input | 32 | Flow identifier |
| in_echo_id | input | 4 | Server ID carried back by a non-initial packet |
| now_time | input | 16 | Free-running time counter |
| fb_valid | input | 1 | Feedback write strobe |
| fb_id | input | 4 | Server the feedback belongs to |
| fb_qlen | input | 16 | Reported queue length |
| fb_vel | input | 8 | Reported drain rate per time unit |
| fb_time | input | 16 | Time stamp of the report |
| out_valid | output | 1 | Decision valid |
| out_id | output | 4 | Chosen server ID |

## Verification
The bound checker watches every cycle. It checks that each key yields exactly one result four cycles later, that an existing flow's output equals its echoed ID, and that a new flow's output is one of its two candidates. It also checks that the choice agrees with the comparison of the two lane estimates, including the tie rule. The estimates themselves are checked only by the bench's scenarios. These cover aging by drain rate, clamping at zero, saturation of the drain product, elapsed time across a counter wrap, and a feedback write that lands in the same cycle as a lookup.

// File: rtl/p2c_pkg.sv
package p2c_pkg;
   // Which of the two hash lanes produced the winning candidate
   typedef enum logic [0:0] {
      PICK_A = 1'b0,
      PICK_B = 1'b1
   } pick_e;

   localparam int unsigned LANES = 2;

   // Odd multipliers for the two independent hash lanes
   localparam logic [31:0] HASH_MULT_A = 32'h9E3779B1;
   localparam logic [31:0] HASH_MULT_B = 32'h85EBCA77;
endpackage

// File: rtl/p2c_hash.sv
module p2c_hash #(
   parameter int unsigned     KEY_W = 32,
   parameter int unsigned     SRV_W = 4,
   parameter logic [KEY_W-1:0] MULT = '1
) (
   input  logic [KEY_W-1:0] key,
   output logic [SRV_W-1:0] idx
);
   // Multiplicative hash: the upper bits of the truncated product mix every key bit
   logic [KEY_W-1:0] mixed;

   assign mixed = key * MULT;
   assign idx   = mixed[KEY_W-1 -: SRV_W];

   if (MULT[0] != 1'b1) begin : g_even_mult
      $error("p2c_hash: multiplier must be odd");
   end
endmodule

// File: rtl/p2c_srv_table.sv
module p2c_srv_table #(
   parameter int unsigned SRV_W    = 4,
   parameter int unsigned LOAD_W   = 16,
   parameter int unsigned VEL_W    = 8,
   parameter int unsigned TIME_W   = 16,
   parameter int unsigned RD_PORTS = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [SRV_W-1:0]                 wr_idx,
   input  logic [LOAD_W-1:0]                wr_qlen,
   input  logic [VEL_W-1:0]                 wr_vel,
   input  logic [TIME_W-1:0]                wr_time,
   input  logic [RD_PORTS-1:0][SRV_W-1:0]   rd_idx,
   output logic [RD_PORTS-1:0][LOAD_W-1:0]  rd_qlen,
   output logic [RD_PORTS-1:0][VEL_W-1:0]   rd_vel,
   output logic [RD_PORTS-1:0][TIME_W-1:0]  rd_time
);
   localparam int unsigned NSRV = 1 << SRV_W;

   logic [LOAD_W-1:0] qlen_q [NSRV];
   logic [VEL_W-1:0]  vel_q  [NSRV];
   logic [TIME_W-1:0] time_q [NSRV];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSRV; i++) begin
            qlen_q[i] <= '0;
            vel_q[i]  <= '0;
            time_q[i] <= '0;
         end
      end else if (wr_en) begin
         qlen_q[wr_idx] <= wr_qlen;
         vel_q[wr_idx]  <= wr_vel;
         time_q[wr_idx] <= wr_time;
      end
   end

   // Asynchronous read: a same-edge write is not yet visible to the reader
   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd_qlen[p] = qlen_q[rd_idx[p]];
      assign rd_vel[p]  = vel_q[rd_idx[p]];
      assign rd_time[p] = time_q[rd_idx[p]];
   end
endmodule

// File: rtl/p2c_load_est.sv
module p2c_load_est #(
   parameter int unsigned LOAD_W = 16,
   parameter int unsigned VEL_W  = 8,
   parameter int unsigned TIME_W = 16
) (
   input  logic              clk,
   input  logic [LOAD_W-1:0] in_qlen,
   input  logic [VEL_W-1:0]  in_vel,
   input  logic [TIME_W-1:0] in_stamp,
   input  logic [TIME_W-1:0] in_now,
   output logic [LOAD_W-1:0] load
);
   localparam int unsigned PROD_W = VEL_W + TIME_W;

   logic [TIME_W-1:0] elapsed;
   logic [PROD_W-1:0] prod_full;
   logic [LOAD_W-1:0] drain;
   logic [LOAD_W-1:0] drain_q;
   logic [LOAD_W-1:0] qlen_q;

   // Modular difference so a wrapped time counter still ages correctly
   assign elapsed   = in_now - in_stamp;
   assign prod_full = PROD_W'(in_vel) * PROD_W'(elapsed);

   if (PROD_W > LOAD_W) begin : g_sat
      assign drain = (|prod_full[PROD_W-1:LOAD_W]) ? {LOAD_W{1'b1}}
                                                    : prod_full[LOAD_W-1:0];
   end else begin : g_fit
      assign drain = LOAD_W'(prod_full);
   end

   // Stage 2: drain amount; stage 3: clamped remainder
   always_ff @(posedge clk) begin
      drain_q <= drain;
      qlen_q  <= in_qlen;
   end

   always_ff @(posedge clk) begin
      load <= (qlen_q > drain_q) ? (qlen_q - drain_q) : '0;
   end
endmodule

// File: rtl/p2c_dispatch.sv
module p2c_dispatch
   import p2c_pkg::*;
#(
   parameter int unsigned      KEY_W  = 32,
   parameter int unsigned      SRV_W  = 4,
   parameter int unsigned      LOAD_W = 16,
   parameter int unsigned      VEL_W  = 8,
   parameter int unsigned      TIME_W = 16,
   parameter logic [KEY_W-1:0] MULT_A = KEY_W'(HASH_MULT_A),
   parameter logic [KEY_W-1:0] MULT_B = KEY_W'(HASH_MULT_B)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_new,
   input  logic [KEY_W-1:0]  in_key,
   input  logic [SRV_W-1:0]  in_echo_id,
   input  logic [TIME_W-1:0] now_time,
   input  logic              fb_valid,
   input  logic [SRV_W-1:0]  fb_id,
   input  logic [LOAD_W-1:0] fb_qlen,
   input  logic [VEL_W-1:0]  fb_vel,
   input  logic [TIME_W-1:0] fb_time,
   output logic              out_valid,
   output logic [SRV_W-1:0]  out_id
);
   localparam int unsigned NL = LANES;

   if (SRV_W < 4 || SRV_W > 8) begin : g_bad_srv_w
      $error("p2c_dispatch: SRV_W must be 4..8 (16..256 servers)");
   end
   if (KEY_W < SRV_W) begin : g_bad_key_w
      $error("p2c_dispatch: KEY_W must cover SRV_W");
   end
   if (MULT_A == MULT_B) begin : g_same_mult
      $error("p2c_dispatch: hash lanes need distinct multipliers");
   end

   // Candidate indices and table reads (combinational, cycle of the key)
   logic [NL-1:0][SRV_W-1:0]  cand_idx;
   logic [NL-1:0][LOAD_W-1:0] rd_qlen;
   logic [NL-1:0][VEL_W-1:0]  rd_vel;
   logic [NL-1:0][TIME_W-1:0] rd_time;

   // Stage 1 registers
   logic                      s1_valid, s1_new;
   logic [SRV_W-1:0]          s1_echo;
   logic [NL-1:0][SRV_W-1:0]  s1_idx;
   logic [NL-1:0][LOAD_W-1:0] s1_qlen;
   logic [NL-1:0][VEL_W-1:0]  s1_vel;
   logic [NL-1:0][TIME_W-1:0] s1_time;
   logic [TIME_W-1:0]         s1_now;

   // Stage 2 and 3 control
   logic                      s2_valid, s2_new, s3_valid, s3_new;
   logic [SRV_W-1:0]          s2_echo, s3_echo;
   logic [NL-1:0][SRV_W-1:0]  s2_idx, s3_idx;

   // Lane load estimates (aligned with stage 3)
   logic [NL-1:0][LOAD_W-1:0] lane_load;

   // Named taps for the bound checker
   logic [SRV_W-1:0]  cand_a, cand_b;
   logic [LOAD_W-1:0] load_a, load_b;

   pick_e pick;

   p2c_srv_table #(
      .SRV_W(SRV_W), .LOAD_W(LOAD_W), .VEL_W(VEL_W), .TIME_W(TIME_W), .RD_PORTS(NL)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (fb_valid),
      .wr_idx  (fb_id),
      .wr_qlen (fb_qlen),
      .wr_vel  (fb_vel),
      .wr_time (fb_time),
      .rd_idx  (cand_idx),
      .rd_qlen (rd_qlen),
      .rd_vel  (rd_vel),
      .rd_time (rd_time)
   );

   for (genvar l = 0; l < NL; l++) begin : g_lane
      localparam logic [KEY_W-1:0] LANE_MULT = (l == 0) ? MULT_A : MULT_B;

      p2c_hash #(.KEY_W(KEY_W), .SRV_W(SRV_W), .MULT(LANE_MULT)) u_hash (
         .key (in_key),
         .idx (cand_idx[l])
      );

      p2c_load_est #(.LOAD_W(LOAD_W), .VEL_W(VEL_W), .TIME_W(TIME_W)) u_est (
         .clk      (clk),
         .in_qlen  (s1_qlen[l]),
         .in_vel   (s1_vel[l]),
         .in_stamp (s1_time[l]),
         .in_now   (s1_now),
         .load     (lane_load[l])
      );
   end

   // Valid pipeline
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s2_valid  <= 1'b0;
         s3_valid  <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         s1_valid  <= in_valid;
         s2_valid  <= s1_valid;
         s3_valid  <= s2_valid;
         out_valid <= s3_valid;
      end
   end

   // Data pipeline
   always_ff @(posedge clk) begin
      s1_new  <= in_new;
      s1_echo <= in_echo_id;
      s1_idx  <= cand_idx;
      s1_qlen <= rd_qlen;
      s1_vel  <= rd_vel;
      s1_time <= rd_time;
      s1_now  <= now_time;
      s2_new  <= s1_new;
      s2_echo <= s1_echo;
      s2_idx  <= s1_idx;
      s3_new  <= s2_new;
      s3_echo <= s2_echo;
      s3_idx  <= s2_idx;
   end

   // Strictly lower lane B wins; ties and identical candidates go to lane A
   assign pick = (lane_load[1] < lane_load[0]) ? PICK_B : PICK_A;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_id <= '0;
      end else if (s3_valid) begin
         if (!s3_new)             out_id <= s3_echo;
         else if (pick == PICK_B) out_id <= s3_idx[1];
         else                     out_id <= s3_idx[0];
      end
   end

   assign cand_a = cand_idx[0];
   assign cand_b = cand_idx[1];
   assign load_a = lane_load[0];
   assign load_b = lane_load[1];
endmodule

// File: rtl/p2c_dispatch_chk.sv
module p2c_dispatch_chk #(
   parameter int unsigned SRV_W  = 4,
   parameter int unsigned LOAD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_new,
   input logic [SRV_W-1:0]  in_echo_id,
   input logic [SRV_W-1:0]  cand_a,
   input logic [SRV_W-1:0]  cand_b,
   input logic [LOAD_W-1:0] load_a,
   input logic [LOAD_W-1:0] load_b,
   input logic              out_valid,
   input logic [SRV_W-1:0]  out_id
);
   AST_KEY_YIELDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##4 out_valid);                                             // R8

   AST_RESULT_HAS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 4));                                       // R8

   AST_ECHO_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(in_new, 4)) |-> (out_id == $past(in_echo_id, 4)));  // R5

   AST_PICK_IS_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_new, 4)) |->
         (out_id == $past(cand_a, 4) || out_id == $past(cand_b, 4)));          // R1

   AST_LOWER_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_new, 4) && ($past(load_b) < $past(load_a))) |->
         (out_id == $past(cand_b, 4)));                                        // R3

   AST_TIE_GOES_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_new, 4) && !($past(load_b) < $past(load_a))) |->
         (out_id == $past(cand_a, 4)));                                        // R4
endmodule

bind p2c_dispatch p2c_dispatch_chk #(.SRV_W(SRV_W), .LOAD_W(LOAD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_new     (in_new),
   .in_echo_id (in_echo_id),
   .cand_a     (cand_a),
   .cand_b     (cand_b),
   .load_a     (load_a),
   .load_b     (load_b),
   .out_valid  (out_valid),
   .out_id     (out_id)
);

// File: tb/tb_p2c_dispatch.sv
module tb_p2c_dispatch;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, in_new, fb_valid;
   logic [31:0] in_key;
   logic [3:0]  in_echo_id, fb_id, out_id;
   logic [15:0] now_time, fb_qlen, fb_time;
   logic [7:0]  fb_vel;
   logic        out_valid;

   always #2 clk = ~clk;   // 250 MHz

   p2c_dispatch dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_new(in_new), .in_key(in_key),
      .in_echo_id(in_echo_id), .now_time(now_time), .fb_valid(fb_valid), .fb_id(fb_id),
      .fb_qlen(fb_qlen), .fb_vel(fb_vel), .fb_time(fb_time),
      .out_valid(out_valid), .out_id(out_id)
   );

   int nchk = 0, nfail = 0;
   bit done = 1'b0;

   // Bench model of server feedback, written from R2/R6
   int          m_g [16];
   int          m_v [16];
   logic [15:0] m_t [16];
   logic [15:0] now_r = 16'd0;

   // Expected-result delay line (slot 3 is due now)
   logic  qv  [4];
   logic [3:0] qid [4];
   string qtag [4];

   typedef struct packed {
      logic [31:0] key;
      logic        nw;
      logic [3:0]  echo;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{32'h0000_0001, 1'b1, 4'd0},  '{32'h1234_5678, 1'b1, 4'd0},
      '{32'hDEAD_BEEF, 1'b0, 4'd9},  '{32'h0BAD_F00D, 1'b1, 4'd0},
      '{32'hCAFE_0042, 1'b1, 4'd0},  '{32'h0000_0000, 1'b0, 4'd15},
      '{32'h7FFF_FFFF, 1'b1, 4'd0},  '{32'hA5A5_5A5A, 1'b0, 4'd3},
      '{32'h0F0F_F0F0, 1'b1, 4'd0},  '{32'hFFFF_FFFF, 1'b1, 4'd0}
   };

   function automatic logic [3:0] hsh(input logic [31:0] k, input logic [31:0] m);
      logic [31:0] p;
      p = k * m;
      return p[31:28];
   endfunction

   function automatic int mload(input int id);
      logic [15:0] dt;
      longint      p;
      dt = now_r - m_t[id];
      p  = longint'(m_v[id]) * longint'(dt);
      if (p > 65535) p = 65535;
      return (longint'(m_g[id]) > p) ? int'(longint'(m_g[id]) - p) : 0;
   endfunction

   function automatic logic [3:0] mpick(input logic [31:0] k);
      logic [3:0] a, b;
      a = hsh(k, 32'h9E3779B1);
      b = hsh(k, 32'h85EBCA77);
      return (mload(int'(b)) < mload(int'(a))) ? b : a;
   endfunction

   function automatic logic [31:0] find_key(input bit same, input logic [31:0] start);
      logic [31:0] k;
      k = start;
      while ((hsh(k, 32'h9E3779B1) == hsh(k, 32'h85EBCA77)) != same) k = k + 1;
      return k;
   endfunction

   task automatic tick(input logic iv, input logic nw, input logic [31:0] key,
                       input logic [3:0] echo, input logic fv, input logic [3:0] fid,
                       input logic [15:0] fq, input logic [7:0] fvl, input logic [15:0] ft,
                       input string tag);
      logic [3:0] e;
      @(negedge clk);
      nchk++;
      if (out_valid !== qv[3] || (qv[3] && out_id !== qid[3])) begin
         nfail++;
         $display("FAIL %s: valid/id got %0b/%0d expected %0b/%0d",
                  qtag[3], out_valid, out_id, qv[3], qid[3]);
      end
      e = nw ? mpick(key) : echo;
      for (int s = 3; s > 0; s--) begin
         qv[s] = qv[s-1]; qid[s] = qid[s-1]; qtag[s] = qtag[s-1];
      end
      qv[0] = iv; qid[0] = e; qtag[0] = iv ? tag : "R8";
      in_valid = iv; in_new = nw; in_key = key; in_echo_id = echo;
      fb_valid = fv; fb_id = fid; fb_qlen = fq; fb_vel = fvl; fb_time = ft;
      now_time = now_r;
      if (fv) begin  // applied after the lookup's expectation (R7)
         m_g[fid] = int'(fq); m_v[fid] = int'(fvl); m_t[fid] = ft;
      end
      now_r = now_r + 16'd1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
   endtask

   task automatic feed(input logic [3:0] id, input logic [15:0] q, input logic [7:0] v,
                       input logic [15:0] t);
      tick(0, 0, 0, 0, 1, id, q, v, t, "R6");
   endtask

   task automatic look(input logic [31:0] k, input string tag);
      tick(1, 1, k, 0, 0, 0, 0, 0, 0, tag);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] kd, ks;
      logic [3:0]  a, b;
      for (int i = 0; i < 16; i++) begin m_g[i] = 0; m_v[i] = 0; m_t[i] = 0; end
      for (int s = 0; s < 4; s++) begin qv[s] = 0; qid[s] = 0; qtag[s] = "R8"; end
      rst_n = 0; in_valid = 0; in_new = 0; in_key = 0; in_echo_id = 0;
      fb_valid = 0; fb_id = 0; fb_qlen = 0; fb_vel = 0; fb_time = 0; now_time = 0;
      repeat (3) @(negedge clk);
      nchk++;
      if (out_valid !== 1'b0) begin
         nfail++; $display("FAIL R9: out_valid in reset got %0b expected 0", out_valid);
      end
      rst_n = 1;

      kd = find_key(1'b0, 32'h0000_1000);
      ks = find_key(1'b1, 32'h0000_2000);
      a  = hsh(kd, 32'h9E3779B1);
      b  = hsh(kd, 32'h85EBCA77);

      // R9: cleared table, candidate A chosen
      look(kd, "R9");
      look(32'h5555_0001, "R9");
      idle(4);

      // R6: program all servers, then walk the vector table back to back (R3, R5, R8)
      for (int i = 0; i < 16; i++) feed(4'(i), 16'(10 + (i * 53) % 97), 8'd3, now_r);
      foreach (VECS[i])
         tick(1, VECS[i].nw, VECS[i].key, VECS[i].echo, 0, 0, 0, 0, 0,
              VECS[i].nw ? "R3" : "R5");
      idle(4);

      // R4: equal loads everywhere, distinct and identical candidates
      for (int i = 0; i < 16; i++) feed(4'(i), 16'd200, 8'd0, 16'd0);
      look(kd, "R4");
      look(ks, "R4");
      idle(4);

      // R2: A ages below B, then clamps at zero
      feed(a, 16'd1000, 8'd10, 16'd1000);
      feed(b, 16'd500, 8'd0, 16'd1000);
      now_r = 16'd1000; look(kd, "R2");
      now_r = 16'd1060; look(kd, "R2");
      now_r = 16'd1200; look(kd, "R2");
      idle(4);

      // R10: 128 * 512 = 65536 must saturate, not wrap to zero
      feed(a, 16'd40000, 8'd128, 16'd3000);
      feed(b, 16'd100, 8'd0, 16'd3000);
      now_r = 16'd3512; look(kd, "R10");
      idle(4);

      // R11: counter has wrapped past the report time (elapsed 56)
      feed(a, 16'd1000, 8'd10, 16'd65500);
      feed(b, 16'd500, 8'd0, 16'd0);
      now_r = 16'd20; look(kd, "R11");
      idle(4);

      // R7 then R6: same-cycle write is invisible, next cycle sees it
      feed(a, 16'd10, 8'd0, 16'd0);
      feed(b, 16'd50, 8'd0, 16'd0);
      tick(1, 1, kd, 0, 1, a, 16'd1000, 8'd0, 16'd0, "R7");
      look(kd, "R6");
      // R5: stored state ignored for an existing flow
      tick(1, 0, kd, a, 0, 0, 0, 0, 0, "R5");
      idle(6);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule